// File: doc/BRIEF.md
# DMA Interrupt Status and Mask Register

This block keeps the interrupt state for a DMA engine with ten channels. Each channel gives a one-cycle pulse when its transfer completes. Three shared sources give their own one-cycle pulses: a stall detector, a memory-FIFO-empty detector and a bus-error detector. Every pulse sets a sticky status bit. The bit stays set until software acknowledges it.

Software uses one 32-bit word, with one read port and one write port. Status bits are write-one-to-clear. Mask bits are write-one-to-toggle. A single write can therefore acknowledge some events and flip the enables of others. The read port always returns the current register contents. The block drives a single interrupt line. That line goes high when an enabled source has its status set. A bus error raises the line whatever the masks hold.

Top module: `dma_irq_status`

## Requirements
- R1: After a synchronous active-low reset, all status and mask bits are zero, the read word is 0 and `irq_o` is low.
- R2: A pulse on `ch_done_i[n]` sets status bit n (bits 9:0) at the next clock edge. The bit stays set until it is cleared.
- R3: A stall pulse sets bit 13, a FIFO-empty pulse sets bit 14 and a bus-error pulse sets bit 15. Each of these bits is sticky.
- R4: A write with a 1 in a status bit position clears that bit. A 0 in that position leaves it unchanged.
- R5: A write with a 1 in a mask position inverts that mask. A 0 leaves it unchanged. Channel n's mask sits at bit 16+n, the stall mask at bit 29 and the FIFO-empty mask at bit 30.
- R6: When an event pulse and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R7: `irq_o` is the registered OR of three terms: each channel status ANDed with its mask, stall status ANDed with bit 29, and FIFO-empty status ANDed with bit 30. It reflects register contents one cycle after they change.
- R8: Bits 12:10, 28:26 and 31 always read as zero, and writing them has no effect.
- R9: One write can clear status bits and toggle mask bits at the same time.
- R10: Bus-error status raises `irq_o` with no mask bit involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ch_done_i | input | 10 | Per-channel completion pulses |
| stall_evt_i | input | 1 | Stall event pulse |
| fifo_empty_evt_i | input | 1 | Memory-FIFO-empty event pulse |
| bus_err_evt_i | input | 1 | Bus-error event pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Write word: 1 clears status bits and toggles mask bits |
| rd_data_o | output | 32 | Current status and mask word |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench drives an event and a clearing write at the same bit in the same cycle. A design that let the clear win would lose the event and read the bit as 0. It writes the same mask bit twice in a row. A design that set the mask, or wrote the data straight in, would leave it at 1 instead of returning it to 0. It checks `irq_o` in the cycle just after a status or mask change. A combinational or twice-registered line would show up one cycle early or one cycle late. It also writes all ones, and writes only to the unused bits. These show whether spare bits ever store data, and whether a bus error ever depends on a mask.

// File: rtl/dma_irq_pkg.sv
// Package: shared widths and bit positions for the DMA interrupt register.
// Assumes channel count stays at or below the stall status position.
package dma_irq_pkg;
    localparam int WORD_W         = 32;
    localparam int NUM_CH         = 10;
    localparam int CH_STAT_LSB    = 0;
    localparam int STALL_STAT_BIT = 13;
    localparam int FIFO_STAT_BIT  = 14;
    localparam int BERR_STAT_BIT  = 15;
    localparam int CH_MASK_LSB    = 16;
    localparam int STALL_MASK_BIT = 29;
    localparam int FIFO_MASK_BIT  = 30;
    // Sticky status vector: channels, then stall, fifo-empty, bus-error.
    localparam int NUM_STAT       = NUM_CH + 3;
    // Mask vector: channels, then stall, fifo-empty (bus error has none).
    localparam int NUM_MASK       = NUM_CH + 2;
endpackage

// File: rtl/irq_sticky_bits.sv
// Module: a row of sticky status flops. An event sets a bit, a clear
// request drops it, and an event in the same cycle wins over the clear.
// Assumes event inputs are single-cycle pulses from the clock domain of clk.
module irq_sticky_bits #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_r;

    // Update each status bit: set has priority over clear, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= set_i | (q_r & ~clr_i);
    end

    assign q_o = q_r;

    for (genvar i = 0; i < W; i++) begin : g_chk
        // R2/R3: a set bit without a clear stays set
        a_r2_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (q_r[i] && !clr_i[i]) |=> q_r[i]);
        // R4: clear without a concurrent event drops the bit
        a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !q_r[i]);
        // R6: an event always lands, even against a clear
        a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> q_r[i]);
    end
endmodule

// File: rtl/irq_toggle_bits.sv
// Module: a row of mask flops, each inverted by a toggle request.
// Assumes toggle requests are already qualified by the write strobe.
module irq_toggle_bits #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] tog_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_r;

    // Invert every bit that has a toggle request this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= q_r ^ tog_i;
    end

    assign q_o = q_r;

    for (genvar i = 0; i < W; i++) begin : g_chk
        // R5: a toggle request flips the bit
        a_r5_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
            tog_i[i] |=> (q_r[i] != $past(q_r[i])));
        // R5: no request, no change
        a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
            !tog_i[i] |=> $stable(q_r[i]));
    end
endmodule

// File: rtl/irq_line_gen.sv
// Module: combines status with masks and registers the interrupt line.
// Assumes the first NM status bits pair index-for-index with the masks,
// and the status bit above them is the unmaskable one.
module irq_line_gen #(
    parameter int NS = 13,
    parameter int NM = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] stat_i,
    input  logic [NM-1:0] mask_i,
    output logic          irq_o
);
    logic irq_d;
    logic irq_r;

    // Any enabled source, or any status bit above the masked range.
    always_comb begin
        irq_d = |(stat_i[NM-1:0] & mask_i);
        for (int k = NM; k < NS; k++) irq_d = irq_d | stat_i[k];
    end

    // Register the line so it is glitch-free at the block edge.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_r <= 1'b0;
        else        irq_r <= irq_d;
    end

    assign irq_o = irq_r;
endmodule

// File: rtl/dma_irq_status.sv
// Module: DMA interrupt status/mask register. Event pulses set sticky
// status bits; software writes clear status (write 1) and toggle masks
// (write 1); a registered line reports any enabled pending source.
// Assumes one write port with a strobe and a read port that is always valid.
module dma_irq_status
    import dma_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_done_i,
    input  logic              stall_evt_i,
    input  logic              fifo_empty_evt_i,
    input  logic              bus_err_evt_i,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic              irq_o
);
    localparam int STAT_STALL = NUM_CH;
    localparam int STAT_FIFO  = NUM_CH + 1;
    localparam int STAT_BERR  = NUM_CH + 2;

    logic [NUM_STAT-1:0] stat_set;
    logic [NUM_STAT-1:0] stat_clr;
    logic [NUM_STAT-1:0] stat_q;
    logic [NUM_MASK-1:0] mask_tog;
    logic [NUM_MASK-1:0] mask_q;
    logic [WORD_W-1:0]   used_bits;
    logic [WORD_W-1:0]   wr_word;

    // Only a strobed write carries clear or toggle requests.
    assign wr_word = wr_en_i ? wr_data_i : '0;

    // Gather event pulses into the status vector order.
    assign stat_set = {bus_err_evt_i, fifo_empty_evt_i, stall_evt_i, ch_done_i};

    // Route each status and mask position of the write word to its flop.
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        assign stat_clr[n] = wr_word[CH_STAT_LSB + n];
        assign mask_tog[n] = wr_word[CH_MASK_LSB + n];
    end
    assign stat_clr[STAT_STALL] = wr_word[STALL_STAT_BIT];
    assign stat_clr[STAT_FIFO]  = wr_word[FIFO_STAT_BIT];
    assign stat_clr[STAT_BERR]  = wr_word[BERR_STAT_BIT];
    assign mask_tog[STAT_STALL] = wr_word[STALL_MASK_BIT];
    assign mask_tog[STAT_FIFO]  = wr_word[FIFO_MASK_BIT];

    irq_sticky_bits #(.W(NUM_STAT)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (stat_set),
        .clr_i (stat_clr),
        .q_o   (stat_q)
    );

    irq_toggle_bits #(.W(NUM_MASK)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .tog_i (mask_tog),
        .q_o   (mask_q)
    );

    irq_line_gen #(.NS(NUM_STAT), .NM(NUM_MASK)) u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat_i (stat_q),
        .mask_i (mask_q),
        .irq_o  (irq_o)
    );

    // Assemble the read word; every unlisted position stays zero.
    always_comb begin
        rd_data_o = '0;
        used_bits = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            rd_data_o[CH_STAT_LSB + n] = stat_q[n];
            rd_data_o[CH_MASK_LSB + n] = mask_q[n];
            used_bits[CH_STAT_LSB + n] = 1'b1;
            used_bits[CH_MASK_LSB + n] = 1'b1;
        end
        rd_data_o[STALL_STAT_BIT] = stat_q[STAT_STALL];
        rd_data_o[FIFO_STAT_BIT]  = stat_q[STAT_FIFO];
        rd_data_o[BERR_STAT_BIT]  = stat_q[STAT_BERR];
        rd_data_o[STALL_MASK_BIT] = mask_q[STAT_STALL];
        rd_data_o[FIFO_MASK_BIT]  = mask_q[STAT_FIFO];
        used_bits[STALL_STAT_BIT] = 1'b1;
        used_bits[FIFO_STAT_BIT]  = 1'b1;
        used_bits[BERR_STAT_BIT]  = 1'b1;
        used_bits[STALL_MASK_BIT] = 1'b1;
        used_bits[FIFO_MASK_BIT]  = 1'b1;
    end

    // R10: a pending bus error always drives the line on the next cycle
    a_r10_berr_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[BERR_STAT_BIT] |=> irq_o);
    // R7: nothing pending means the line is low one cycle later
    a_r7_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o[BERR_STAT_BIT:0] == '0) |=> !irq_o);
    // R8: a write that touches only unused bits, with no events, changes nothing
    a_r8_spare_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && ((wr_data_i & used_bits) == '0) && (stat_set == '0))
        |=> $stable(rd_data_o));
    // R1: the read word is zero right after reset
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (rd_data_o == '0 && !irq_o));
endmodule

// File: tb/sim_dma_irq_status.sv
`timescale 1ns/1ps
module sim_dma_irq_status;
    localparam logic [31:0] STAT_BITS = 32'h0000_E3FF;
    localparam logic [31:0] MASK_BITS = 32'h63FF_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  ch_done = '0;
    logic        stall_evt = 1'b0;
    logic        fifo_evt = 1'b0;
    logic        berr_evt = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int bad = 0;
    logic [31:0] mdl = '0;
    logic        done = 1'b0;

    always #2.5 clk = ~clk;

    dma_irq_status u0 (
        .clk(clk), .rst_n(rst_n), .ch_done_i(ch_done),
        .stall_evt_i(stall_evt), .fifo_empty_evt_i(fifo_evt),
        .bus_err_evt_i(berr_evt), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_data_o(rd_data), .irq_o(irq)
    );

    // Expected interrupt level for a given register word.
    function automatic logic irq_of(input logic [31:0] w);
        logic r;
        r = |(w[9:0] & w[25:16]);
        r = r | (w[13] & w[29]) | (w[14] & w[30]) | w[15];
        return r;
    endfunction

    // Expected register word after one clock edge.
    function automatic logic [31:0] next_of(input logic [31:0] w, input logic [31:0] ev,
                                            input logic we, input logic [31:0] wd);
        logic [31:0] c;
        c = we ? wd : 32'h0;
        return (ev & STAT_BITS) | (w & STAT_BITS & ~c) | ((w & MASK_BITS) ^ (c & MASK_BITS));
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive, clock, update the model, compare word and line.
    task automatic step(input logic [9:0] ch, input logic st, input logic ff, input logic be,
                        input logic we, input logic [31:0] wd, input string tag);
        logic [31:0] ev;
        logic exp_irq;
        ch_done = ch; stall_evt = st; fifo_evt = ff; berr_evt = be;
        wr_en = we; wr_data = wd;
        ev = {16'h0, be, ff, st, 3'b000, ch};
        @(posedge clk); #1;
        exp_irq = irq_of(mdl);
        mdl = next_of(mdl, ev, we, wd);
        check({tag, " word"}, rd_data, mdl);
        check({"R7 line"}, {31'h0, irq}, {31'h0, exp_irq});
        ch_done = '0; stall_evt = 0; fifo_evt = 0; berr_evt = 0; wr_en = 0; wr_data = '0;
    endtask

    task automatic idle(input string tag);
        step('0, 0, 0, 0, 0, 32'h0, tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset word", rd_data, 32'h0);
        check("R1 reset line", {31'h0, irq}, 32'h0);
        rst_n = 1'b1;

        // R2: channel 3 and 9 events, sticky across idle cycles
        step(10'h208, 0, 0, 0, 0, 32'h0, "R2 ch events");
        idle("R2 sticky");
        idle("R2 sticky");
        // R3: shared sources land at 13,14,15; R10 line follows bus error
        step('0, 1, 1, 0, 0, 32'h0, "R3 stall fifo");
        step('0, 0, 0, 1, 0, 32'h0, "R3 berr");
        idle("R10 berr line");
        // R4: clear bus error and channel 3 only; zeros leave the rest
        step('0, 0, 0, 0, 1, 32'h0000_8008, "R4 clear");
        idle("R4 after clear");
        // R5: toggle channel 9 mask twice, back to zero
        step('0, 0, 0, 0, 1, 32'h0200_0000, "R5 toggle on");
        idle("R7 ch9 enabled");
        step('0, 0, 0, 0, 1, 32'h0200_0000, "R5 toggle off");
        idle("R7 ch9 disabled");
        // R5: stall and fifo masks at 29 and 30
        step('0, 0, 0, 0, 1, 32'h6000_0000, "R5 shared masks");
        idle("R7 shared enabled");
        // R6: event and clear on channel 0 in the same cycle
        step(10'h001, 0, 0, 0, 1, 32'h0000_0001, "R6 event wins");
        // R9: clear stall and toggle fifo mask in one write
        step('0, 0, 0, 0, 1, 32'h4000_2000, "R9 mixed write");
        idle("R9 after");
        // R8: write only unused bits, then all ones
        step('0, 0, 0, 0, 1, 32'h9C00_1C00, "R8 spare write");
        step('0, 0, 0, 0, 1, 32'hFFFF_FFFF, "R8 all ones");
        idle("R8 readback");
        // Constrained random mix of events and writes
        for (int i = 0; i < 2000; i++) begin
            logic [9:0] ch;
            logic [31:0] wd;
            logic we;
            ch = ($urandom_range(0, 3) == 0) ? 10'($urandom) & 10'($urandom) : '0;
            we = ($urandom_range(0, 2) == 0);
            wd = $urandom & $urandom;
            step(ch, ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0),
                 ($urandom_range(0, 31) == 0), we, wd, "R4 random");
        end
        // R1: reset mid-run clears everything
        rst_n = 1'b0;
        @(posedge clk); #1;
        mdl = '0;
        check("R1 second reset word", rd_data, 32'h0);
        @(posedge clk); #1;
        check("R1 second reset line", {31'h0, irq}, 32'h0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule